// File: doc/BRIEF.md
# Pushbutton Port Command Register Bank

This block is the command and state register bank of a four-port power controller. It sits on a simple byte-wide bus with a write strobe, an address, write data and combinational read data. Three of its addresses are write-one-to-trigger command registers. A 1 written to a bit fires that bit's action, a 0 bit does nothing, and a read of any of them returns zero. These registers request detection and classification cycles, switch port power on or off, and clear a single port or the whole bank. A fourth address holds the read/write detection and classification enable bits.

Each command that is accepted becomes a per-port pulse one clock wide, for the analog and sequencing logic outside this block. The bank also keeps the state of each port: power-enable, detect and fault event flags, a small status code loaded from detection results, and the enable bits. Each port works in one of four modes. Ports in manual mode run one cycle for each request, and their enable bits clear when the matching done input arrives. Ports in semiauto and auto mode keep their enable bits set. Turning a port off by command wipes all of that port's state.

Top module: `pb_port_cmd_bank`

## Requirements
- R1: After reset, power-enable, all events, all status codes and all enable bits are zero, and every command pulse output is low.
- R2: Reads at 18h, 19h and 1Ah return 00h. Writing 0 to a command bit has no effect.
- R3: A write to 18h pulses det_go[p] for each set bit p in 3:0 and cls_go[p] for each set bit 4+p. The pulse is high for exactly the one cycle after the write. A port in shutdown mode gets no pulse and no enable change. port_mode[2p+1:2p] encodes the mode: 00 shutdown, 01 manual, 10 semiauto, 11 auto.
- R4: A restart write to 18h sets the matching enable bits at 14h (detect in 3:0, classify in 7:4) and leaves every other enable bit unchanged.
- R5: 14h is read/write. For a manual-mode port, a bit that the write takes from 0 to 1 pulses that port's det_go or cls_go. Semiauto and auto ports get no pulse.
- R6: For a manual-mode port, det_done[p] clears detect-enable bit p and cls_done[p] clears classify-enable bit 4+p. Enable bits of semiauto and auto ports are kept.
- R7: A write to 19h sets power-enable for each set bit p in 3:0 and pulses pwr_on_go[p]. It clears power-enable for each set bit 4+p and pulses pwr_off_go[p]. Ports in shutdown mode ignore both. Power-enable reads at 10h, bits 3:0.
- R8: While cooldown_active[p] is high, a set request for port p is refused and no pwr_on_go pulse is produced.
- R9: If one write to 19h both sets and clears the same port, the clear wins.
- R10: A clear through 19h also zeroes that port's detect and fault event bits, its status code and both of its enable bits.
- R11: A write to 1Ah applies the R10 clearing to each port p whose bit p is set, in any mode, and pulses port_rst_go[p] for one cycle.
- R12: Writing 1Ah bit 4 returns every register to its reset value and pulses glob_rst_go for one cycle. Bit 5 of 1Ah has no effect.
- R13: fault_trip[p] clears power-enable for port p and sets its fault event. det_done[p] sets the detect event and loads det_result[3p+2:3p] into the status code. Events read at 11h: fault in 7:4, detect in 3:0. Port p's status reads at 0Ch+p in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| port_mode | input | 8 | Two mode bits per port |
| det_done | input | 4 | Detection cycle finished, per port |
| cls_done | input | 4 | Classification cycle finished, per port |
| det_result | input | 12 | Three-bit detection result per port |
| fault_trip | input | 4 | Overcurrent or startup fault turned port off |
| cooldown_active | input | 4 | Fault cooldown timer still running |
| pwr_en | output | 4 | Per-port power-enable |
| det_go | output | 4 | Start a detection cycle |
| cls_go | output | 4 | Start a classification cycle |
| pwr_on_go | output | 4 | Power-on command accepted |
| pwr_off_go | output | 4 | Power-off command accepted |
| port_rst_go | output | 4 | Per-port reset command |
| glob_rst_go | output | 1 | Global reset command |

## Verification
The assertions assume three things about the inputs. The done and fault inputs are single-cycle events. The mode and cooldown inputs change only between bus writes, never in the cycle a command is taken. A pulse output is only traced back to a write strobe in the previous cycle. The stimulus keeps to these rules: modes, cooldown flags and detection results are changed only around read cycles, and each done or fault input is driven for exactly one idle cycle.

// File: rtl/pb_port_cmd_bank.sv
module pb_port_cmd_bank #(
  parameter int         STAT_W    = 3,
  parameter logic [7:0] A_STAT0   = 8'h0C,
  parameter logic [7:0] A_PWR     = 8'h10,
  parameter logic [7:0] A_EVT     = 8'h11,
  parameter logic [7:0] A_EN      = 8'h14,
  parameter logic [7:0] A_RESTART = 8'h18,
  parameter logic [7:0] A_PWRCMD  = 8'h19,
  parameter logic [7:0] A_RSTCMD  = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        port_mode,
  input  logic [3:0]        det_done,
  input  logic [3:0]        cls_done,
  input  logic [4*STAT_W-1:0] det_result,
  input  logic [3:0]        fault_trip,
  input  logic [3:0]        cooldown_active,
  output logic [3:0]        pwr_en,
  output logic [3:0]        det_go,
  output logic [3:0]        cls_go,
  output logic [3:0]        pwr_on_go,
  output logic [3:0]        pwr_off_go,
  output logic [3:0]        port_rst_go,
  output logic              glob_rst_go
);
  localparam int         NP    = 4;
  localparam logic [1:0] M_OFF = 2'b00;
  localparam logic [1:0] M_MAN = 2'b01;

  wire wr_en  = bus_wr && (bus_addr == A_EN);
  wire wr_rs  = bus_wr && (bus_addr == A_RESTART);
  wire wr_pw  = bus_wr && (bus_addr == A_PWRCMD);
  wire wr_rc  = bus_wr && (bus_addr == A_RSTCMD);
  wire glob   = wr_rc && bus_wdata[4];

  logic [NP-1:0] shut, man, rs_det, rs_cls, off_cmd, on_ok, clr;
  logic [NP-1:0] det_en_q, cls_en_q, det_evt_q, flt_evt_q;
  logic [STAT_W-1:0] stat_q [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign shut[p]    = port_mode[2*p +: 2] == M_OFF;
    assign man[p]     = port_mode[2*p +: 2] == M_MAN;
    assign rs_det[p]  = wr_rs & bus_wdata[p] & ~shut[p];
    assign rs_cls[p]  = wr_rs & bus_wdata[NP+p] & ~shut[p];
    assign off_cmd[p] = wr_pw & bus_wdata[NP+p] & ~shut[p];
    assign on_ok[p]   = wr_pw & bus_wdata[p] & ~shut[p] & ~bus_wdata[NP+p]
                        & ~cooldown_active[p] & ~fault_trip[p];
    assign clr[p]     = off_cmd[p] | (wr_rc & bus_wdata[p]);
  end

  wire [NP-1:0] man_det = {NP{wr_en}} & bus_wdata[NP-1:0] & ~det_en_q & man;
  wire [NP-1:0] man_cls = {NP{wr_en}} & bus_wdata[2*NP-1:NP] & ~cls_en_q & man;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_en      <= '0;
      det_en_q    <= '0;
      cls_en_q    <= '0;
      det_evt_q   <= '0;
      flt_evt_q   <= '0;
      det_go      <= '0;
      cls_go      <= '0;
      pwr_on_go   <= '0;
      pwr_off_go  <= '0;
      port_rst_go <= '0;
      glob_rst_go <= 1'b0;
      for (int p = 0; p < NP; p++) stat_q[p] <= '0;
    end else if (glob) begin
      pwr_en      <= '0;
      det_en_q    <= '0;
      cls_en_q    <= '0;
      det_evt_q   <= '0;
      flt_evt_q   <= '0;
      det_go      <= '0;
      cls_go      <= '0;
      pwr_on_go   <= '0;
      pwr_off_go  <= '0;
      port_rst_go <= '0;
      glob_rst_go <= 1'b1;
      for (int p = 0; p < NP; p++) stat_q[p] <= '0;
    end else begin
      glob_rst_go <= 1'b0;
      det_go      <= rs_det | man_det;
      cls_go      <= rs_cls | man_cls;
      pwr_on_go   <= on_ok;
      pwr_off_go  <= off_cmd;
      port_rst_go <= wr_rc ? bus_wdata[NP-1:0] : '0;
      for (int p = 0; p < NP; p++) begin
        if (clr[p]) begin
          pwr_en[p]    <= 1'b0;
          det_en_q[p]  <= 1'b0;
          cls_en_q[p]  <= 1'b0;
          det_evt_q[p] <= 1'b0;
          flt_evt_q[p] <= 1'b0;
          stat_q[p]    <= '0;
        end else begin
          if (fault_trip[p])  pwr_en[p] <= 1'b0;
          else if (on_ok[p])  pwr_en[p] <= 1'b1;

          if (wr_en)                         det_en_q[p] <= bus_wdata[p];
          else if (rs_det[p])                det_en_q[p] <= 1'b1;
          else if (man[p] && det_done[p])    det_en_q[p] <= 1'b0;

          if (wr_en)                         cls_en_q[p] <= bus_wdata[NP+p];
          else if (rs_cls[p])                cls_en_q[p] <= 1'b1;
          else if (man[p] && cls_done[p])    cls_en_q[p] <= 1'b0;

          if (det_done[p]) begin
            det_evt_q[p] <= 1'b1;
            stat_q[p]    <= det_result[p*STAT_W +: STAT_W];
          end
          if (fault_trip[p]) flt_evt_q[p] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_PWR:   bus_rdata = {4'h0, pwr_en};
      A_EVT:   bus_rdata = {flt_evt_q, det_evt_q};
      A_EN:    bus_rdata = {cls_en_q, det_en_q};
      default: begin
        for (int p = 0; p < NP; p++)
          if (bus_addr == A_STAT0 + 8'(p)) bus_rdata[STAT_W-1:0] = stat_q[p];
      end
    endcase
  end
endmodule

// File: rtl/pb_port_cmd_bank_chk.sv
module pb_port_cmd_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] port_mode,
  input logic [3:0] cooldown_active,
  input logic [3:0] pwr_en,
  input logic [3:0] det_go,
  input logic [3:0] cls_go,
  input logic [3:0] pwr_on_go,
  input logic [3:0] pwr_off_go,
  input logic [3:0] port_rst_go,
  input logic       glob_rst_go
);
  a_r2_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h18 || bus_addr == 8'h19 || bus_addr == 8'h1A) |-> bus_rdata == 8'h00);

  a_r3_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|{det_go, cls_go, pwr_on_go, pwr_off_go, port_rst_go, glob_rst_go}) |-> $past(bus_wr));

  a_r12_global_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h1A && bus_wdata[4]) |=> (pwr_en == 4'h0 && glob_rst_go));

  for (genvar p = 0; p < 4; p++) begin : g_chk
    a_r7_shutdown_no_power: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en[p]) |-> $past(port_mode[2*p +: 2] != 2'b00));

    a_r8_cooldown_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h19 && bus_wdata[p] && cooldown_active[p] && !pwr_en[p])
      |=> (!pwr_en[p] && !pwr_on_go[p]));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 8'h19 && bus_wdata[4+p] && port_mode[2*p +: 2] != 2'b00)
      |=> !pwr_en[p]);
  end
endmodule

bind pb_port_cmd_bank pb_port_cmd_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_mode(port_mode),
  .cooldown_active(cooldown_active), .pwr_en(pwr_en), .det_go(det_go),
  .cls_go(cls_go), .pwr_on_go(pwr_on_go), .pwr_off_go(pwr_off_go),
  .port_rst_go(port_rst_go), .glob_rst_go(glob_rst_go)
);

// File: tb/test_pb_port_cmd_bank.sv
module test_pb_port_cmd_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  port_mode = 8'h55;
  logic [3:0]  det_done = 4'h0;
  logic [3:0]  cls_done = 4'h0;
  logic [11:0] det_result = 12'h000;
  logic [3:0]  fault_trip = 4'h0;
  logic [3:0]  cooldown_active = 4'h0;
  logic [3:0]  pwr_en, det_go, cls_go, pwr_on_go, pwr_off_go, port_rst_go;
  logic        glob_rst_go;

  always #2 clk = ~clk;

  pb_port_cmd_bank i_pb_port_cmd_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_mode(port_mode),
    .det_done(det_done), .cls_done(cls_done), .det_result(det_result),
    .fault_trip(fault_trip), .cooldown_active(cooldown_active),
    .pwr_en(pwr_en), .det_go(det_go), .cls_go(cls_go), .pwr_on_go(pwr_on_go),
    .pwr_off_go(pwr_off_go), .port_rst_go(port_rst_go), .glob_rst_go(glob_rst_go)
  );

  localparam int S_RD = 0, S_DET = 1, S_CLS = 2, S_ON = 3, S_OFF = 4,
                 S_PRST = 5, S_GRST = 6, S_PWR = 7;

  typedef struct {
    int         cyc;
    int         sel;
    logic [7:0] val;
    string      req;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [7:0] got;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      S_RD:    return bus_rdata;
      S_DET:   return {4'h0, det_go};
      S_CLS:   return {4'h0, cls_go};
      S_ON:    return {4'h0, pwr_on_go};
      S_OFF:   return {4'h0, pwr_off_go};
      S_PRST:  return {4'h0, port_rst_go};
      S_GRST:  return {7'h0, glob_rst_go};
      default: return {4'h0, pwr_en};
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        got = observe(sbq[i].sel);
        nvec++;
        if (got !== sbq[i].val) begin
          nfail++;
          $display("FAIL %s sel=%0d cycle=%0d actual=%02h expected=%02h",
                   sbq[i].req, sbq[i].sel, cyc, got, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] dd, input logic [3:0] cd, input logic [3:0] ft);
    @(posedge clk);
    #1;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    det_done = dd; cls_done = cd; fault_trip = ft;
  endtask

  task automatic expect_at(input int off, input int sel, input logic [7:0] val, input string req);
    item_t it;
    it.cyc = cyc + off; it.sel = sel; it.val = val; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b1, a, d, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
    step(1'b0, a, 8'h00, 4'h0, 4'h0, 4'h0);
    expect_at(0, S_RD, e, req);
  endtask

  task automatic idle_in(input logic [3:0] dd, input logic [3:0] cd, input logic [3:0] ft);
    step(1'b0, 8'h00, 8'h00, dd, cd, ft);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h14, 8'h00, "R1");
    expect_at(0, S_DET, 8'h00, "R1");
    expect_at(0, S_PWR, 8'h00, "R1");
    rd(8'h11, 8'h00, "R1");
    rd(8'h0C, 8'h00, "R1");

    // R3/R4 restart in manual mode
    det_result = 12'h005;
    wr(8'h18, 8'h21);
    expect_at(1, S_DET, 8'h01, "R3");
    expect_at(1, S_CLS, 8'h02, "R3");
    expect_at(2, S_DET, 8'h00, "R3");
    rd(8'h18, 8'h00, "R2");
    rd(8'h14, 8'h21, "R4");
    idle_in(4'h1, 4'h0, 4'h0);
    rd(8'h14, 8'h20, "R6");
    rd(8'h0C, 8'h05, "R13");
    rd(8'h11, 8'h01, "R13");
    idle_in(4'h0, 4'h2, 4'h0);
    rd(8'h14, 8'h00, "R6");

    // R5 enable register with port2 auto
    port_mode = 8'h75;
    det_result = 12'h0C0;
    wr(8'h14, 8'h44);
    expect_at(1, S_DET, 8'h00, "R5");
    expect_at(1, S_CLS, 8'h00, "R5");
    rd(8'h14, 8'h44, "R5");
    wr(8'h14, 8'h45);
    expect_at(1, S_DET, 8'h01, "R5");
    rd(8'h14, 8'h45, "R5");
    idle_in(4'hF, 4'h0, 4'h0);
    rd(8'h14, 8'h44, "R6");
    rd(8'h11, 8'h0F, "R13");
    rd(8'h0E, 8'h03, "R13");

    // R7/R8/R9 power commands
    wr(8'h19, 8'h03);
    expect_at(1, S_ON, 8'h03, "R7");
    rd(8'h10, 8'h03, "R7");
    rd(8'h19, 8'h00, "R2");
    cooldown_active = 4'h4;
    wr(8'h19, 8'h04);
    expect_at(1, S_ON, 8'h00, "R8");
    rd(8'h10, 8'h03, "R8");
    cooldown_active = 4'h0;
    port_mode = 8'h35;
    wr(8'h19, 8'h08);
    rd(8'h10, 8'h03, "R7");
    wr(8'h19, 8'h80);
    expect_at(1, S_OFF, 8'h00, "R7");
    wr(8'h19, 8'h22);
    expect_at(1, S_ON, 8'h00, "R9");
    expect_at(1, S_OFF, 8'h02, "R9");
    rd(8'h10, 8'h01, "R9");
    rd(8'h11, 8'h0D, "R10");

    // R13 fault and R10 cascade on port2
    wr(8'h19, 8'h04);
    rd(8'h10, 8'h05, "R7");
    idle_in(4'h0, 4'h0, 4'h1);
    rd(8'h10, 8'h04, "R13");
    rd(8'h11, 8'h1D, "R13");
    wr(8'h19, 8'h40);
    expect_at(1, S_OFF, 8'h04, "R10");
    rd(8'h10, 8'h00, "R10");
    rd(8'h11, 8'h19, "R10");
    rd(8'h14, 8'h00, "R10");
    rd(8'h0E, 8'h00, "R10");

    // R11 per-port reset, including a shutdown port
    wr(8'h1A, 8'h01);
    expect_at(1, S_PRST, 8'h01, "R11");
    rd(8'h11, 8'h08, "R11");
    rd(8'h0C, 8'h00, "R11");
    wr(8'h1A, 8'h08);
    expect_at(1, S_PRST, 8'h08, "R11");
    rd(8'h11, 8'h00, "R11");

    // R3 restart on a shutdown port
    wr(8'h18, 8'h88);
    expect_at(1, S_DET, 8'h00, "R3");
    expect_at(1, S_CLS, 8'h00, "R3");
    rd(8'h14, 8'h00, "R3");

    // R2 zero write has no effect
    wr(8'h18, 8'h00);
    expect_at(1, S_DET, 8'h00, "R2");
    rd(8'h14, 8'h00, "R2");

    // R12 global reset and reserved bit
    wr(8'h14, 8'hFF);
    expect_at(1, S_DET, 8'h03, "R5");
    expect_at(1, S_CLS, 8'h03, "R5");
    wr(8'h19, 8'h01);
    rd(8'h10, 8'h01, "R7");
    wr(8'h1A, 8'h20);
    expect_at(1, S_GRST, 8'h00, "R12");
    rd(8'h10, 8'h01, "R12");
    rd(8'h14, 8'hFF, "R12");
    wr(8'h1A, 8'h10);
    expect_at(1, S_GRST, 8'h01, "R12");
    rd(8'h10, 8'h00, "R12");
    rd(8'h14, 8'h00, "R12");
    rd(8'h11, 8'h00, "R12");

    repeat (4) idle_in(4'h0, 4'h0, 4'h0);
    if (sbq.size() != 0) begin
      nfail++;
      $display("FAIL scoreboard left %0d unchecked items", sbq.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule